// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This block gathers the interrupt causes of a network controller into one 32-bit status word and drives a single active-low interrupt line. Single-cycle event pulses from the transmit and receive DMA logic are caught in sticky bits. Level summaries from six sub-modules (link coding, transmit MAC, receive MAC, MAC control, management interface, host bus errors) are shown as they are, and stay set until their sources drop them. The upper field of the word shows the current 13-bit completion index of transmit queue 3, taken from an input.

Software reaches the block through a small register port with four word addresses. There is a primary status view, a mask register, an alias-clear register and an alias status view. Reading the primary view clears every sticky event bit. Reading the alias view returns the same word but clears only the sticky bits picked out by the alias-clear register. A polling driver can therefore consume some causes and leave the others pending. A summary bit in the word shows whether the interrupt line is asserted at that moment.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the sticky event bits are 0, the mask register reads 0x0007FFFF (all 19 mask bits set), the alias-clear register reads 0, and `irq_n` is high.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets status bit i (bits 0..9) from that edge on. The bit stays set until a clearing read.
- R3: A read at address 0 (primary status) returns the status word and clears all sticky bits 0..9 at that clock edge.
- R4: A read at address 3 (alias status) returns the same word as address 0 and clears only the sticky bits whose bit is set in the alias-clear register (address 2). All other sticky bits keep their value.
- R5: An event pulse in the same cycle as a clearing read leaves its bit set after the read.
- R6: Status bits 13..18 equal `src_level[5:0]` in every cycle. No read clears them.
- R7: Status bits 19..31 equal `txq3_index[12:0]` in every cycle.
- R8: `irq_n` goes low one clock after any status bit in 0..9 or 13..18 is set while its mask bit is 0. It returns high one clock after no such bit remains. Masked bits never pull it low.
- R9: Status bit 12 reads 1 exactly while `irq_n` is low. Bits 10 and 11 read 0.
- R10: Writes to addresses 0 and 3 change nothing. A write to address 1 loads mask bits 18..0 (upper bits read 0). A write to address 2 loads alias-clear bits 9..0 (upper bits read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 10 | Single-cycle event pulses for sticky bits 0..9 |
| src_level | input | 6 | Level summaries of the second-level sources |
| txq3_index | input | 13 | Current completion index of transmit queue 3 |
| rd_en | input | 1 | Read strobe; one cycle performs one read |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | 0 primary status, 1 mask, 2 alias-clear, 3 alias status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` while `rd_en` is high, else 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two things can land on the same sticky bit in the same clock edge: a new event pulse, and a read that clears that bit. The bench sets one event, then issues a primary read in the very cycle a second event pulses. It checks that the read returns the old event, and that a later non-clearing look shows only the new one. For the alias view, it loads a partial alias-clear pattern and checks that only the chosen bits are gone after the read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DEF_EVT_W = 10;
    localparam int DEF_LVL_W = 6;
    localparam int DEF_IDX_W = 13;
    localparam int DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        ADR_STATUS = 2'd0,
        ADR_MASK   = 2'd1,
        ADR_ACLR   = 2'd2,
        ADR_ALIAS  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[b] <= 1'b0;
            end else begin
                // a set in the same cycle as a clear wins
                q_o[b] <= (q_o[b] & ~clr_i[b]) | set_i[b];
            end
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_agg_pkg::*;
#(
    parameter int MASK_W = 19,
    parameter int ACLR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [MASK_W-1:0] wdata,
    output logic [MASK_W-1:0] mask_o,
    output logic [ACLR_W-1:0] aclr_o
);

    logic hit_mask;
    logic hit_aclr;

    always_comb begin
        hit_mask = wr_en && (reg_addr_e'(addr) == ADR_MASK);
        hit_aclr = wr_en && (reg_addr_e'(addr) == ADR_ACLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (hit_mask) begin
            mask_o <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aclr_o <= '0;
        end else if (hit_aclr) begin
            aclr_o <= wdata[ACLR_W-1:0];
        end
    end

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int                 W     = 19,
    parameter logic [W-1:0]       CAUSE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_q
);

    logic pending;

    always_comb begin
        pending = |(status_i & ~mask_i & CAUSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pending;
        end
    end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int EVT_W  = DEF_EVT_W,
    parameter int LVL_W  = DEF_LVL_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic [LVL_W-1:0]  src_level,
    input  logic [IDX_W-1:0]  txq3_index,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);

    // word layout: events, two idle bits, summary, levels, index
    localparam int SUM_BIT = EVT_W + 2;
    localparam int LVL_LSB = SUM_BIT + 1;
    localparam int MASK_W  = LVL_LSB + LVL_W;
    localparam logic [MASK_W-1:0] CAUSE = {{LVL_W{1'b1}}, 3'b000, {EVT_W{1'b1}}};

    logic [EVT_W-1:0]  evt_q;
    logic [EVT_W-1:0]  clr_vec;
    logic [MASK_W-1:0] mask_q;
    logic [EVT_W-1:0]  aclr_q;
    logic              irq_q;
    logic [MASK_W-1:0] cause_view;
    logic [DATA_W-1:0] status_word;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:MASK_W];

    always_comb begin
        clr_vec = '0;
        if (rd_en) begin
            if (reg_addr_e'(addr) == ADR_STATUS) begin
                clr_vec = '1;
            end else if (reg_addr_e'(addr) == ADR_ALIAS) begin
                clr_vec = aclr_q;
            end
        end
    end

    irq_event_latch #(.W(EVT_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse),
        .clr_i (clr_vec),
        .q_o   (evt_q)
    );

    irq_ctrl_regs #(.MASK_W(MASK_W), .ACLR_W(EVT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata[MASK_W-1:0]),
        .mask_o (mask_q),
        .aclr_o (aclr_q)
    );

    always_comb begin
        cause_view = {src_level, 3'b000, evt_q};
    end

    irq_line_gen #(.W(MASK_W), .CAUSE(CAUSE)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (cause_view),
        .mask_i   (mask_q),
        .irq_q    (irq_q)
    );

    always_comb begin
        status_word = {txq3_index, src_level, irq_q, 2'b00, evt_q};
        irq_n = ~irq_q;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (reg_addr_e'(addr))
                ADR_STATUS: rdata = status_word;
                ADR_ALIAS:  rdata = status_word;
                ADR_MASK:   rdata = {{(DATA_W-MASK_W){1'b0}}, mask_q};
                ADR_ACLR:   rdata = {{(DATA_W-EVT_W){1'b0}}, aclr_q};
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
    import irq_agg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] evt_pulse,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [9:0] evt_bits,
    input logic [9:0] mask_lo,
    input logic [9:0] aclr,
    input logic       irq_n
);

    // R5 / R2: a pulsed event is present after its edge, even under a clearing read
    p_event_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((evt_bits & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: a primary read with no new event empties the sticky bits
    p_primary_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && evt_pulse == '0) |=> (evt_bits == '0));

    // R4: alias read leaves unselected bits alone
    p_alias_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=>
        ((evt_bits & $past(evt_bits & ~aclr)) == $past(evt_bits & ~aclr)));

    // R8: an unmasked event pulls the line low two edges later
    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_pulse & ~mask_lo) != '0) && !wr_en) |=> ##1 !irq_n);

    // R10: a write to the status address does not disturb the sticky bits
    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == 2'd0 && evt_pulse == '0) |=>
        (evt_bits == $past(evt_bits)));

endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .evt_bits  (evt_q),
    .mask_lo   (mask_q[9:0]),
    .aclr      (aclr_q),
    .irq_n     (irq_n)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_pulse = '0;
    logic [5:0]  src_level = '0;
    logic [12:0] txq3_index = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_status_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .src_level(src_level),
        .txq3_index(txq3_index), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_n", {31'b0, irq_n}, 32'd1);
        do_read(2'd3, d); check("R1 status", d, 32'h0);
        do_read(2'd1, d); check("R1 mask", d, 32'h0007FFFF);
        do_read(2'd2, d); check("R1 aclr", d, 32'h0);
    endtask

    task automatic t_event();
        logic [31:0] d;
        do_write(2'd1, 32'h0);
        pulse(10'h008);
        do_read(2'd3, d); check("R2 R9 set+summary", d, 32'h00001008);
        check("R8 irq low", {31'b0, irq_n}, 32'd0);
        do_read(2'd0, d); check("R3 primary value", d, 32'h00001008);
        do_read(2'd3, d); check("R3 cleared", d, 32'h0);
        idle(1);
        check("R8 irq high", {31'b0, irq_n}, 32'd1);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        do_write(2'd2, 32'h005);
        pulse(10'h00F);
        do_read(2'd3, d); check("R4 alias value", d, 32'h0000100F);
        do_read(2'd3, d); check("R4 selective clear", d, 32'h0000100A);
        do_write(2'd2, 32'h0);
        do_read(2'd0, d);
        idle(3);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(10'h002);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd0; evt_pulse = 10'h020;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; evt_pulse = '0;
        check("R5 read value", d, 32'h00001002);
        do_read(2'd3, d); check("R5 event kept", d, 32'h00001020);
        do_read(2'd0, d);
        idle(3);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_write(2'd1, 32'h0007FFFF);
        pulse(10'h080);
        idle(3);
        check("R8 masked no irq", {31'b0, irq_n}, 32'd1);
        do_read(2'd3, d); check("R9 summary zero", d, 32'h00000080);
        do_write(2'd1, 32'h0007FF7F);
        idle(1);
        check("R8 unmask asserts", {31'b0, irq_n}, 32'd0);
        do_read(2'd0, d);
        idle(3);
        check("R8 deassert", {31'b0, irq_n}, 32'd1);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        @(negedge clk); src_level = 6'h25;
        do_read(2'd0, d); check("R6 level view", d, 32'h25 << 13);
        do_read(2'd0, d); check("R6 not cleared", d, 32'h25 << 13);
        check("R8 level masked", {31'b0, irq_n}, 32'd1);
        do_write(2'd1, 32'h00077FFF);
        idle(1);
        check("R8 level irq", {31'b0, irq_n}, 32'd0);
        @(negedge clk); src_level = '0;
        idle(2);
        check("R6 R8 source drop", {31'b0, irq_n}, 32'd1);
    endtask

    task automatic t_index();
        logic [31:0] d;
        @(negedge clk); txq3_index = 13'h1ABC;
        do_read(2'd3, d); check("R7 index", d, {13'h1ABC, 19'h0});
        @(negedge clk); txq3_index = 13'h0001;
        do_read(2'd0, d); check("R7 index live", d, {13'h0001, 19'h0});
    endtask

    task automatic t_writes();
        logic [31:0] d;
        do_write(2'd1, 32'h0007FFFF);
        pulse(10'h200);
        do_write(2'd0, 32'h0);
        do_write(2'd3, 32'h0);
        do_read(2'd3, d); check("R10 status write ignored", {22'b0, d[9:0]}, 32'h200);
        do_read(2'd1, d); check("R10 mask untouched", d, 32'h0007FFFF);
        do_write(2'd2, 32'hFFFFFFFF);
        do_read(2'd2, d); check("R10 aclr width", d, 32'h000003FF);
        do_write(2'd1, 32'hFFFFFFFF);
        do_read(2'd1, d); check("R10 mask width", d, 32'h0007FFFF);
        do_read(2'd3, d); check("R4 full alias clear value", {22'b0, d[9:0]}, 32'h200);
        do_read(2'd3, d); check("R4 full alias cleared", {22'b0, d[9:0]}, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_event();
        t_alias();
        t_collide();
        t_mask();
        t_levels();
        t_index();
        t_writes();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule